// File: doc/BRIEF.md
# Posted-Write Buffer Controller with Bandwidth-Aware Forwarding

This block holds posted writes inside a bus bridge. One side supplies write transactions. Each transaction is a start address followed by data beats. The other side drains them as bursts, and each burst carries its start address. Both sides run on one clock. A per-side beat-enable strobe models each side's transfer rate: a beat moves only in a cycle where the strobe, valid and ready are all high. Four static configuration inputs give each side's data width in bytes and its rate factor. The block multiplies these to get a bandwidth figure for each side and picks a forwarding mode. If the supplying side is slower than the draining side, a transaction is held until it has been terminated and is then forwarded. Otherwise a burst starts as soon as a programmable number of beats is buffered.

The supplying side gets one of three answers. A beat can be accepted. A beat can be accepted while the transaction is cut off (a disconnect). An opening beat can be refused so that the initiator must try again later (a retry). After the buffer has been filled by a disconnect, it is refilled one cache line per transaction, until it has fully drained. Two counters report how many retries and disconnects have been issued.

Both data interfaces use valid/ready with a beat-enable. On the supplying side, `up_valid`, `up_addr`, `up_data`, `up_last` and `up_wi` must stay steady until the beat is taken or retry is signalled. After a retry the initiator lowers `up_valid` and may try again later. On the draining side, `dn_valid`, `dn_addr`, `dn_data` and `dn_last` stay steady while no beat is taken. A beat moves only when `dn_valid`, `dn_ready` and `dn_en` are all high.

Top module: `pwb_buffer`

## Requirements
- R1: `mode_sf` is 1 (store-and-forward) exactly when `cfg_up_bytes*cfg_up_rate` is less than `cfg_dn_bytes*cfg_dn_rate`. Equal bandwidth gives 0 (flow-through).
- R2: In store-and-forward mode, `dn_valid` does not rise for a transaction until the upstream beat that terminated it (by `up_last` or by disconnect) has been taken.
- R3: In flow-through mode, `dn_valid` rises once `cfg_thresh` beats of the head transaction are buffered, while that upstream transaction is still open.
- R4: An opening beat is answered with `up_retry`=1 and `up_ready`=0 when free buffer space is below LINE beats. A free space of exactly LINE is accepted.
- R5: A normal write transaction that fills the buffer is disconnected on the beat that fills it (`up_disc`=1 with that beat). With DEPTH=16 it takes exactly 16 beats.
- R6: After such a fill, every later transaction is disconnected after exactly LINE beats (4 by default). This lasts until the buffer has drained empty. After that, transactions may again run to their own last beat.
- R7: A write-and-invalidate transaction (`up_wi`=1) is disconnected only at a cache-line boundary, when the space left after that line is below LINE.
- R8: Downstream beats carry the upstream data in the same order. `dn_addr` is the transaction start address plus 4 bytes (the default data width) per beat.
- R9: Each upstream termination produces exactly one downstream `dn_last`, on that transaction's final beat. Transactions are never merged into one burst.
- R10: `retry_cnt` increments once for each cycle in which `up_retry` is high with `up_en`. `disc_cnt` increments once for each disconnect.
- R11: After reset, `dn_valid`=0, `retry_cnt`=0 and `disc_cnt`=0.
- R12: While `dn_valid` is high and no beat is taken (`dn_ready` or `dn_en` low), `dn_valid`, `dn_addr`, `dn_data` and `dn_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_up_bytes | input | 8 | Supplying side data width in bytes |
| cfg_up_rate | input | 8 | Supplying side rate factor |
| cfg_dn_bytes | input | 8 | Draining side data width in bytes |
| cfg_dn_rate | input | 8 | Draining side rate factor |
| cfg_thresh | input | 5 | Beats buffered before a flow-through burst starts |
| mode_sf | output | 1 | 1 = store-and-forward, 0 = flow-through |
| up_en | input | 1 | Supplying side beat-enable strobe |
| up_valid | input | 1 | Upstream beat offered |
| up_addr | input | 32 | Transaction start address, read on the opening beat |
| up_data | input | 32 | Upstream beat data |
| up_last | input | 1 | Initiator's final beat |
| up_wi | input | 1 | Write-and-invalidate transaction, read on the opening beat |
| up_ready | output | 1 | Beat can be taken |
| up_retry | output | 1 | Opening beat refused; try again later |
| up_disc | output | 1 | Beat taken and transaction cut off |
| dn_en | input | 1 | Draining side beat-enable strobe |
| dn_valid | output | 1 | Downstream beat offered |
| dn_ready | input | 1 | Downstream sink can take a beat |
| dn_addr | output | 32 | Address of the current downstream beat |
| dn_data | output | 32 | Downstream beat data |
| dn_last | output | 1 | Final beat of a forwarded transaction |
| retry_cnt | output | 16 | Number of retries issued |
| disc_cnt | output | 16 | Number of disconnects issued |

## Verification
The hardest state to reach is line-granular refill. The buffer must first be filled by one long transaction while the draining side is held off. After that, the draining side is released for an exact number of beats, and only then is the next write offered. The stimulus holds `dn_ready` low and lets the first write hit the depth. It then opens `dn_ready` for three beats and expects a retry at one beat short of a line. One more beat is released, and each follow-on write must then stop after exactly one line. The write-and-invalidate case starts from a partial fill of ten beats, so that its line-boundary disconnect comes out at a different beat count than a normal write would give.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int CFG_W = 8;

  function automatic logic [2*CFG_W-1:0] side_bw(input logic [CFG_W-1:0] bytes_i,
                                                 input logic [CFG_W-1:0] rate_i);
    return (2*CFG_W)'(bytes_i) * (2*CFG_W)'(rate_i);
  endfunction
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdata = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full || pop);
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/pwb_mode.sv
module pwb_mode
  import pwb_pkg::*;
(
  input  logic [CFG_W-1:0] up_bytes,
  input  logic [CFG_W-1:0] up_rate,
  input  logic [CFG_W-1:0] dn_bytes,
  input  logic [CFG_W-1:0] dn_rate,
  output logic             sf
);
  logic [2*CFG_W-1:0] up_bw, dn_bw;

  always_comb begin
    up_bw = side_bw(up_bytes, up_rate);
    dn_bw = side_bw(dn_bytes, dn_rate);
    sf    = (up_bw < dn_bw);
  end

  always_comb begin
    if (up_bw == dn_bw) p_equal_ft_r1: assert (!sf);
  end
endmodule

// File: rtl/pwb_up_ctrl.sv
module pwb_up_ctrl #(
  parameter int DEPTH = 16,
  parameter int LINE  = 4,
  parameter int CW    = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LB    = (LINE > 1) ? $clog2(LINE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_en,
  input  logic             up_valid,
  input  logic             up_last,
  input  logic             up_wi,
  input  logic [CNT_W-1:0] data_count,
  input  logic             data_full,
  input  logic             aq_full,
  output logic             up_ready,
  output logic             up_retry,
  output logic             up_disc,
  output logic             push,
  output logic             push_last,
  output logic             aq_push,
  output logic [CW-1:0]    retry_cnt,
  output logic [CW-1:0]    disc_cnt
);
  logic             in_txn, wi_q, line_mode;
  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] free, free_after;
  logic             blocked, wi_eff, line_end, space_stop, cap_stop, fire;

  always_comb begin
    free       = CNT_W'(DEPTH) - data_count;
    free_after = free - 1'b1;
    blocked    = (free < CNT_W'(LINE)) || aq_full;
    wi_eff     = in_txn ? wi_q : up_wi;
    line_end   = (beat_cnt[LB-1:0] == LB'(LINE - 1));
    space_stop = wi_eff ? (line_end && (free_after < CNT_W'(LINE)))
                        : (free_after == '0);
    cap_stop   = line_mode && (beat_cnt == CNT_W'(LINE - 1));
    up_retry   = up_valid && !in_txn && blocked;
    up_ready   = in_txn ? !data_full : (up_valid && !blocked);
    fire       = up_valid && up_ready && up_en;
    up_disc    = fire && !up_last && (space_stop || cap_stop);
    push       = fire;
    push_last  = up_last || up_disc;
    aq_push    = fire && !in_txn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_txn    <= 1'b0;
      wi_q      <= 1'b0;
      beat_cnt  <= '0;
      line_mode <= 1'b0;
      retry_cnt <= '0;
      disc_cnt  <= '0;
    end else begin
      if (fire) begin
        if (!in_txn) wi_q <= up_wi;
        if (push_last) begin
          in_txn   <= 1'b0;
          beat_cnt <= '0;
        end else begin
          in_txn   <= 1'b1;
          beat_cnt <= beat_cnt + 1'b1;
        end
      end
      if (up_disc && space_stop)
        line_mode <= 1'b1;
      else if (data_count == '0 && !in_txn)
        line_mode <= 1'b0;
      if (up_retry && up_en) retry_cnt <= retry_cnt + 1'b1;
      if (up_disc)           disc_cnt  <= disc_cnt + 1'b1;
    end
  end

  p_start_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_txn) |-> (free >= CNT_W'(LINE)));
  p_line_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mode && in_txn) |-> (beat_cnt < CNT_W'(LINE)));
  p_wi_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_disc && wi_eff) |-> line_end);
  p_retry_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_retry |-> !up_ready);
endmodule

// File: rtl/pwb_dn_ctrl.sv
module pwb_dn_ctrl #(
  parameter int DW       = 32,
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 16,
  parameter int AQ_DEPTH = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int AQC_W  = $clog2(AQ_DEPTH + 1),
  localparam int BSH    = $clog2(DW / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_mode,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic [CNT_W-1:0]  data_count,
  input  logic              data_empty,
  input  logic              head_last,
  input  logic [ADDR_W-1:0] aq_addr,
  input  logic              aq_empty,
  input  logic [AQC_W-1:0]  aq_count,
  input  logic              closed_in,
  input  logic              dn_ready,
  input  logic              dn_en,
  output logic              dn_valid,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_last,
  output logic              pop,
  output logic              aq_pop
);
  logic [AQC_W-1:0] closed_cnt;
  logic [CNT_W-1:0] offset;
  logic             in_burst, head_closed, start_ok;

  always_comb begin
    head_closed = (closed_cnt != '0);
    start_ok    = sf_mode ? head_closed
                          : (head_closed || (data_count >= cfg_thresh));
    dn_valid    = !data_empty && !aq_empty && (in_burst || start_ok);
    dn_last     = head_last;
    dn_addr     = aq_addr + (ADDR_W'(offset) << BSH);
    pop         = dn_valid && dn_ready && dn_en;
    aq_pop      = pop && head_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      closed_cnt <= '0;
      offset     <= '0;
      in_burst   <= 1'b0;
    end else begin
      case ({closed_in, aq_pop})
        2'b10:   closed_cnt <= closed_cnt + 1'b1;
        2'b01:   closed_cnt <= closed_cnt - 1'b1;
        default: closed_cnt <= closed_cnt;
      endcase
      if (pop) begin
        if (head_last) begin
          offset   <= '0;
          in_burst <= 1'b0;
        end else begin
          offset   <= offset + 1'b1;
          in_burst <= 1'b1;
        end
      end
    end
  end

  p_sf_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_mode && dn_valid && !in_burst) |-> head_closed);
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !dn_last) |=> (dn_addr == $past(dn_addr) + ADDR_W'(DW / 8)));
  p_closed_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    closed_cnt <= aq_count);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !(dn_ready && dn_en)) |=> (dn_valid && $stable(dn_addr) && $stable(dn_last)));
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer
  import pwb_pkg::*;
#(
  parameter int DW       = 32,
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 16,
  parameter int LINE     = 4,
  parameter int AQ_DEPTH = 4,
  parameter int CW       = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CFG_W-1:0]             cfg_up_bytes,
  input  logic [CFG_W-1:0]             cfg_up_rate,
  input  logic [CFG_W-1:0]             cfg_dn_bytes,
  input  logic [CFG_W-1:0]             cfg_dn_rate,
  input  logic [$clog2(DEPTH+1)-1:0]   cfg_thresh,
  output logic                         mode_sf,
  input  logic                         up_en,
  input  logic                         up_valid,
  input  logic [ADDR_W-1:0]            up_addr,
  input  logic [DW-1:0]                up_data,
  input  logic                         up_last,
  input  logic                         up_wi,
  output logic                         up_ready,
  output logic                         up_retry,
  output logic                         up_disc,
  input  logic                         dn_en,
  output logic                         dn_valid,
  input  logic                         dn_ready,
  output logic [ADDR_W-1:0]            dn_addr,
  output logic [DW-1:0]                dn_data,
  output logic                         dn_last,
  output logic [CW-1:0]                retry_cnt,
  output logic [CW-1:0]                disc_cnt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AQC_W = $clog2(AQ_DEPTH + 1);

  logic             push, push_last, pop, aq_push, aq_pop;
  logic [DW:0]      head_word;
  logic [CNT_W-1:0] data_count;
  logic             data_full, data_empty;
  logic [ADDR_W-1:0] aq_addr;
  logic [AQC_W-1:0] aq_count;
  logic             aq_full, aq_empty;

  pwb_mode u_mode (
    .up_bytes (cfg_up_bytes),
    .up_rate  (cfg_up_rate),
    .dn_bytes (cfg_dn_bytes),
    .dn_rate  (cfg_dn_rate),
    .sf       (mode_sf)
  );

  pwb_up_ctrl #(.DEPTH(DEPTH), .LINE(LINE), .CW(CW)) u_up (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_en      (up_en),
    .up_valid   (up_valid),
    .up_last    (up_last),
    .up_wi      (up_wi),
    .data_count (data_count),
    .data_full  (data_full),
    .aq_full    (aq_full),
    .up_ready   (up_ready),
    .up_retry   (up_retry),
    .up_disc    (up_disc),
    .push       (push),
    .push_last  (push_last),
    .aq_push    (aq_push),
    .retry_cnt  (retry_cnt),
    .disc_cnt   (disc_cnt)
  );

  pwb_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_data_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata ({push_last, up_data}),
    .pop   (pop),
    .rdata (head_word),
    .count (data_count),
    .full  (data_full),
    .empty (data_empty)
  );

  pwb_fifo #(.W(ADDR_W), .DEPTH(AQ_DEPTH)) u_addr_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (aq_push),
    .wdata (up_addr),
    .pop   (aq_pop),
    .rdata (aq_addr),
    .count (aq_count),
    .full  (aq_full),
    .empty (aq_empty)
  );

  pwb_dn_ctrl #(.DW(DW), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .AQ_DEPTH(AQ_DEPTH)) u_dn (
    .clk        (clk),
    .rst_n      (rst_n),
    .sf_mode    (mode_sf),
    .cfg_thresh (cfg_thresh),
    .data_count (data_count),
    .data_empty (data_empty),
    .head_last  (head_word[DW]),
    .aq_addr    (aq_addr),
    .aq_empty   (aq_empty),
    .aq_count   (aq_count),
    .closed_in  (push && push_last),
    .dn_ready   (dn_ready),
    .dn_en      (dn_en),
    .dn_valid   (dn_valid),
    .dn_addr    (dn_addr),
    .dn_last    (dn_last),
    .pop        (pop),
    .aq_pop     (aq_pop)
  );

  assign dn_data = head_word[DW-1:0];
endmodule

// File: tb/pwb_buffer_bench.sv
`timescale 1ns/1ps
module pwb_buffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_up_bytes = 8'd8, cfg_up_rate = 8'd1, cfg_dn_bytes = 8'd8, cfg_dn_rate = 8'd1;
  logic [4:0] cfg_thresh = 5'd2;
  logic mode_sf;
  logic up_en = 1'b1, up_valid = 1'b0, up_last = 1'b0, up_wi = 1'b0;
  logic [31:0] up_addr = '0, up_data = '0;
  logic up_ready, up_retry, up_disc;
  logic dn_en = 1'b0, dn_ready = 1'b0;
  logic dn_valid, dn_last;
  logic [31:0] dn_addr, dn_data;
  logic [15:0] retry_cnt, disc_cnt;

  always #2.5 clk = ~clk;

  pwb_buffer u_pwb_buffer (
    .clk(clk), .rst_n(rst_n),
    .cfg_up_bytes(cfg_up_bytes), .cfg_up_rate(cfg_up_rate),
    .cfg_dn_bytes(cfg_dn_bytes), .cfg_dn_rate(cfg_dn_rate),
    .cfg_thresh(cfg_thresh), .mode_sf(mode_sf),
    .up_en(up_en), .up_valid(up_valid), .up_addr(up_addr), .up_data(up_data),
    .up_last(up_last), .up_wi(up_wi), .up_ready(up_ready), .up_retry(up_retry),
    .up_disc(up_disc), .dn_en(dn_en), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_data(dn_data), .dn_last(dn_last),
    .retry_cnt(retry_cnt), .disc_cnt(disc_cnt)
  );

  int total = 0, bad = 0, cycles = 0, open_dn = 0;
  bit up_open = 1'b0;
  logic [31:0] seq = 32'h0000_1000;
  logic [31:0] exp_d[$], exp_a[$];
  bit exp_l[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // bandwidth mode table: up_bytes, up_rate, dn_bytes, dn_rate, expected mode_sf (R1)
  localparam logic [32:0] MODE_TAB [5] = '{
    {8'd8, 8'd1, 8'd8, 8'd2, 1'b1},
    {8'd8, 8'd2, 8'd8, 8'd1, 1'b0},
    {8'd8, 8'd1, 8'd8, 8'd1, 1'b0},
    {8'd4, 8'd2, 8'd8, 8'd1, 1'b0},
    {8'd4, 8'd1, 8'd8, 8'd1, 1'b1}
  };

  // downstream monitor: beat moves at the coming edge when all three are high (R8, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (up_open && dn_valid) open_dn++;
      if (dn_valid && dn_ready && dn_en) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R9", "unexpected downstream beat", 1, 0);
        end else begin
          logic [31:0] ed, ea;
          bit el;
          ed = exp_d.pop_front(); ea = exp_a.pop_front(); el = exp_l.pop_front();
          chk(dn_data == ed, "R8", "dn_data order", int'(dn_data), int'(ed));
          chk(dn_addr == ea, "R8", "dn_addr step", int'(dn_addr), int'(ea));
          chk(dn_last == el, "R9", "dn_last boundary", int'(dn_last), int'(el));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic up_txn(input logic [31:0] addr, input int n, input bit wi,
                        output int acc, output bit dsc, output bit rty);
    bit done;
    acc = 0; dsc = 0; rty = 0; done = 0;
    @(posedge clk); #1;
    up_open = 1; up_valid = 1; up_addr = addr; up_wi = wi; up_data = seq; up_last = (n == 1);
    while (!done) begin
      @(negedge clk);
      if (up_retry) begin
        rty = 1; done = 1;
        @(posedge clk); #1;
      end else if (up_ready && up_en) begin
        exp_d.push_back(seq);
        exp_a.push_back(addr + 32'(acc * 4));
        exp_l.push_back(up_last || up_disc);
        dsc = up_disc;
        done = up_last || up_disc;
        acc++; seq++;
        @(posedge clk); #1;
        up_data = seq; up_last = (acc == n - 1);
      end else begin
        @(posedge clk); #1;
      end
    end
    up_valid = 0; up_last = 0; up_wi = 0; up_open = 0;
  endtask

  task automatic pop_n(input int n);
    @(posedge clk); #1; dn_ready = 1; dn_en = 1;
    repeat (n) @(posedge clk);
    #1; dn_ready = 0;
  endtask

  task automatic drain();
    dn_ready = 1; dn_en = 1;
    while (exp_d.size() != 0) @(negedge clk);
    @(posedge clk); #1; dn_ready = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    int acc;
    bit dsc, rty;
    logic [31:0] first_d;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    chk(dn_valid == 0, "R11", "dn_valid after reset", int'(dn_valid), 0);
    chk(retry_cnt == 0, "R11", "retry_cnt after reset", int'(retry_cnt), 0);
    chk(disc_cnt == 0, "R11", "disc_cnt after reset", int'(disc_cnt), 0);

    for (int i = 0; i < 5; i++) begin
      {cfg_up_bytes, cfg_up_rate, cfg_dn_bytes, cfg_dn_rate} = MODE_TAB[i][32:1];
      #1;
      chk(mode_sf == MODE_TAB[i][0], "R1", "mode_sf from table", int'(mode_sf), int'(MODE_TAB[i][0]));
    end

    // store-and-forward: slow supplier
    cfg_up_bytes = 8'd8; cfg_up_rate = 8'd1; cfg_dn_bytes = 8'd8; cfg_dn_rate = 8'd2;
    dn_ready = 1; dn_en = 1; open_dn = 0;
    up_txn(32'h0000_0200, 5, 0, acc, dsc, rty);
    chk(acc == 5, "R2", "sf beats accepted", acc, 5);
    drain();
    chk(open_dn == 0, "R2", "dn_valid while upstream open", open_dn, 0);

    // flow-through, threshold 2
    cfg_up_rate = 8'd2; cfg_thresh = 5'd2; #1;
    chk(mode_sf == 0, "R3", "flow-through selected", int'(mode_sf), 0);
    dn_ready = 1; dn_en = 1; open_dn = 0;
    up_txn(32'h0000_0300, 6, 0, acc, dsc, rty);
    drain();
    chk(open_dn > 0, "R3", "dn_valid during open txn", open_dn, 1);

    // fill, retry, line-granular refill
    up_txn(32'h0000_0100, 20, 0, acc, dsc, rty);
    first_d = exp_d[0];
    chk(acc == 16, "R5", "beats before full disconnect", acc, 16);
    chk(dsc == 1, "R5", "disconnect at full", int'(dsc), 1);
    @(negedge clk);
    chk(dn_valid == 1 && dn_data == first_d, "R12", "head data stalled", int'(dn_data), int'(first_d));
    @(posedge clk); #1; dn_ready = 1; dn_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dn_valid == 1 && dn_data == first_d && dn_addr == 32'h100, "R12", "hold with en low",
        int'(dn_addr), 32'h100);
    #1; dn_ready = 0;
    up_txn(32'h0000_0400, 4, 0, acc, dsc, rty);
    chk(rty == 1 && acc == 0, "R4", "retry when full", int'(rty), 1);
    pop_n(3);
    up_txn(32'h0000_0400, 4, 0, acc, dsc, rty);
    chk(rty == 1, "R4", "retry at free=LINE-1", int'(rty), 1);
    pop_n(1);
    up_txn(32'h0000_0500, 10, 0, acc, dsc, rty);
    chk(acc == 4 && dsc == 1, "R6", "one line then disconnect (a)", acc, 4);
    pop_n(8);
    up_txn(32'h0000_0600, 10, 0, acc, dsc, rty);
    chk(acc == 4 && dsc == 1, "R6", "one line then disconnect (b)", acc, 4);
    chk(retry_cnt == 2, "R10", "retry_cnt", int'(retry_cnt), 2);
    chk(disc_cnt == 3, "R10", "disc_cnt", int'(disc_cnt), 3);
    drain();
    up_txn(32'h0000_0700, 6, 0, acc, dsc, rty);
    chk(acc == 6 && dsc == 0, "R6", "line mode cleared after empty", acc, 6);
    drain();

    // write-and-invalidate at partial fill
    up_txn(32'h0000_0800, 10, 0, acc, dsc, rty);
    chk(acc == 10 && dsc == 0, "R7", "normal fill of ten", acc, 10);
    up_txn(32'h0000_0900, 8, 1, acc, dsc, rty);
    chk(acc == 4 && dsc == 1, "R7", "wi stops at line boundary", acc, 4);
    chk(disc_cnt == 4, "R10", "disc_cnt after wi", int'(disc_cnt), 4);
    drain();
    chk(exp_d.size() == 0, "R9", "all beats forwarded", exp_d.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule